// File: doc/BRIEF.md
# Timer Compare Output Pin Driver

This block keeps the output-compare level for one channel of a 16-bit timer and places that level on a general-purpose I/O pin. A compare-match pulse from the counter applies an action to the stored level. A 2-bit action field selects that action: no action, toggle, clear or set. In non-PWM operation a force strobe applies the same action at once, without a real match. The counter, its match detection and PWM waveform shaping sit outside this block.

The pin normally carries the port's data bit. The compare level replaces that bit only when two conditions hold together: the action field is nonzero and the channel's pin-takeover enable is set. The port's direction bit alone decides whether the pin drives. Software can therefore set the stored level with the force strobe while the takeover is off. When the takeover is switched on, the pin shows a known level.

The stored level is a two-state machine with states LVL_LOW and LVL_HIGH. Reset enters LVL_LOW. An update event is a match pulse, or a force strobe while PWM operation is off. On an event, ACT_SET moves to LVL_HIGH and ACT_CLEAR moves to LVL_LOW. ACT_TOGGLE moves to the other state. ACT_NONE keeps the current state. With no event the state is kept.

Top module: `cmp_pin_driver`

## Requirements
- R1: After active-low reset the stored compare level is 0. The pin therefore reads 0 once the takeover is enabled with a nonzero action field and no event has occurred.
- R2: With action field 01 (toggle), each update event inverts the stored level.
- R3: With action field 10 an update event stores 0. With action field 11 an update event stores 1.
- R4: With action field 00 an update event leaves the stored level unchanged.
- R5: pin_out equals the stored level when act_mode is nonzero and pin_takeover is 1. Otherwise pin_out equals port_data.
- R6: pin_oe always equals port_dir.
- R7: A change of act_mode without an update event does not change the stored level. The new field value acts first at the next event.
- R8: When pwm_sel is 0, force_cmp applies the selected action at the clock edge that samples it, with no match pulse.
- R9: When pwm_sel is 1, force_cmp has no effect on the stored level.
- R10: When match and an effective force strobe arrive in the same cycle, the action is applied once, so a toggle inverts the level only once.
- R11: The stored level can be set or cleared by force strobes while pin_takeover is 0. The pin shows that level as soon as the takeover is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match | input | 1 | Compare-match pulse from the counter |
| force_cmp | input | 1 | Force-compare strobe |
| pwm_sel | input | 1 | 1 while a PWM waveform mode is selected |
| act_mode | input | 2 | Action field: 00 none, 01 toggle, 10 clear, 11 set |
| pin_takeover | input | 1 | Per-pin enable for the compare takeover |
| port_data | input | 1 | Port data register bit |
| port_dir | input | 1 | Port direction bit (1 = output) |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
Directed sequences try each action code on a match pulse and on a force strobe. Each sequence is followed by a read-out through the pin, which separates a toggle from a set that lands on the same level. Some sequences change the action field between events, to show that a field write alone moves nothing. Others send a force strobe with PWM operation selected, and others send a match and a force in the same cycle, which exposes a double toggle. A seeded random run then mixes all inputs freely. Each cycle is compared against a bench model, which separates takeover gating faults from direction faults.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/cmp_event_gate.sv
module cmp_event_gate (
    input  logic match,
    input  logic force_cmp,
    input  logic pwm_sel,
    output logic upd_evt
);
    logic force_ok;

    // A force strobe counts only outside PWM operation; match and force merge into one event.
    always_comb begin
        force_ok = force_cmp & ~pwm_sel;
        upd_evt  = match | force_ok;
    end
endmodule

// File: rtl/cmp_level_fsm.sv
module cmp_level_fsm
    import cmp_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_evt,
    input  logic [ACT_W-1:0] act_mode,
    output logic             level
);
    lvl_e state_q, state_d;
    act_e act;

    assign act = act_e'(act_mode);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (upd_evt) begin
            unique case (state_q)
                LVL_LOW: begin
                    if (act == ACT_SET || act == ACT_TOGGLE) state_d = LVL_HIGH;
                end
                LVL_HIGH: begin
                    if (act == ACT_CLEAR || act == ACT_TOGGLE) state_d = LVL_LOW;
                end
                default: state_d = LVL_LOW;
            endcase
        end
    end

    always_comb begin
        level = (state_q == LVL_HIGH);
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt && act_mode == 2'b01 |=> level != $past(level)); // R2
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt && act_mode == 2'b10 |=> !level); // R3
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt && act_mode == 2'b11 |=> level); // R3
    AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt && act_mode == 2'b00 |=> $stable(level)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(level)); // R7
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_pin_pkg::*;
(
    input  logic             level,
    input  logic [ACT_W-1:0] act_mode,
    input  logic             pin_takeover,
    input  logic             port_data,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);
    logic takeover;

    always_comb begin
        takeover = (act_mode != ACT_NONE) && pin_takeover;
        pin_out  = takeover ? level : port_data;
        pin_oe   = port_dir;
    end
endmodule

// File: rtl/cmp_pin_driver.sv
module cmp_pin_driver
    import cmp_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match,
    input  logic             force_cmp,
    input  logic             pwm_sel,
    input  logic [ACT_W-1:0] act_mode,
    input  logic             pin_takeover,
    input  logic             port_data,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);
    logic upd_evt;
    logic level;

    cmp_event_gate u_gate (
        .match     (match),
        .force_cmp (force_cmp),
        .pwm_sel   (pwm_sel),
        .upd_evt   (upd_evt)
    );

    cmp_level_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_evt  (upd_evt),
        .act_mode (act_mode),
        .level    (level)
    );

    cmp_pin_mux u_mux (
        .level        (level),
        .act_mode     (act_mode),
        .pin_takeover (pin_takeover),
        .port_data    (port_data),
        .port_dir     (port_dir),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_sel && force_cmp && !match |=> $stable(level)); // R9
    AST_FORCE_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_sel && force_cmp && act_mode == 2'b11 |=> level); // R8
endmodule

// File: tb/tb_cmp_pin_driver.sv
module tb_cmp_pin_driver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       match, force_cmp, pwm_sel, pin_takeover, port_data, port_dir;
    logic [1:0] act_mode;
    logic       pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    logic m_lvl;  // bench model of the stored level

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_pin_driver dut (
        .clk(clk), .rst_n(rst_n), .match(match), .force_cmp(force_cmp),
        .pwm_sel(pwm_sel), .act_mode(act_mode), .pin_takeover(pin_takeover),
        .port_data(port_data), .port_dir(port_dir),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic next_lvl(logic cur, logic [1:0] md, logic mt, logic fc, logic pw);
        logic ev;
        ev = mt | (fc & ~pw);
        if (!ev) return cur;
        case (md)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    function automatic logic exp_pin(logic lv, logic [1:0] md, logic tk, logic pd);
        return (md != 2'b00 && tk) ? lv : pd;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at negedge, clock once, sample just after the edge.
    task automatic step(logic mt, logic fc);
        @(negedge clk);
        match = mt; force_cmp = fc;
        m_lvl = next_lvl(m_lvl, act_mode, mt, fc, pwm_sel);
        @(posedge clk); #1;
        match = 1'b0; force_cmp = 1'b0;
    endtask

    // Read the stored level out through the pin without any event.
    task automatic peek(string req);
        logic [1:0] keep_md;
        logic keep_tk;
        keep_md = act_mode; keep_tk = pin_takeover;
        @(negedge clk);
        act_mode = 2'b11; pin_takeover = 1'b1; #1;
        check(req, pin_out, m_lvl);
        act_mode = keep_md; pin_takeover = keep_tk;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; match = 0; force_cmp = 0; pwm_sel = 0; act_mode = 2'b00;
        pin_takeover = 0; port_data = 0; port_dir = 0; m_lvl = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        peek("R1 reset level");
        @(negedge clk); act_mode = 2'b00; pin_takeover = 1; port_data = 1; port_dir = 1; #1;
        check("R5 mode 00 passes port data", pin_out, 1'b1);
        check("R6 oe follows dir", pin_oe, 1'b1);
        port_dir = 0; #1;
        check("R6 oe follows dir low", pin_oe, 1'b0);

        act_mode = 2'b01;
        step(1, 0); peek("R2 toggle to 1");
        step(1, 0); peek("R2 toggle to 0");
        act_mode = 2'b11; step(1, 0); peek("R3 set");
        act_mode = 2'b10; step(1, 0); peek("R3 clear");
        act_mode = 2'b11; step(1, 0);
        act_mode = 2'b00; step(1, 0); peek("R4 none holds");

        act_mode = 2'b10; step(0, 0); step(0, 0); peek("R7 mode write alone holds");
        step(1, 0); peek("R7 new mode at next match");

        pwm_sel = 0; act_mode = 2'b11; step(0, 1); peek("R8 force set");
        act_mode = 2'b10; step(0, 1); peek("R8 force clear");
        pwm_sel = 1; act_mode = 2'b11; step(0, 1); peek("R9 force ignored in pwm");
        pwm_sel = 0; act_mode = 2'b01; step(1, 1); peek("R10 single toggle");

        @(negedge clk); pin_takeover = 0; port_data = 0;
        act_mode = 2'b11; step(0, 1);
        #1 check("R5 takeover off shows port", pin_out, 1'b0);
        @(negedge clk); pin_takeover = 1; #1;
        check("R11 preset level appears", pin_out, 1'b1);

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            act_mode = 2'($urandom_range(0, 3));
            pwm_sel = 1'($urandom_range(0, 1));
            pin_takeover = 1'($urandom_range(0, 1));
            port_data = 1'($urandom_range(0, 1));
            port_dir = 1'($urandom_range(0, 1));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            check("R5 random pin value", pin_out, exp_pin(m_lvl, act_mode, pin_takeover, port_data));
            check("R6 random oe", pin_oe, port_dir);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule